// File: doc/BRIEF.md
# I2C Master Control Register and Bit-Rate Block

This block holds the byte-wide control and status registers of an I2C master controller, and the generator that sets the SCL bit rate. A host reaches six 8-bit registers over a simple single-cycle bus: mode, own address, rate divider, command, event and interrupt mask. Every access completes in the cycle it is presented. There is no back-pressure, and read data is valid in the same cycle as the address.

A separate bit engine uses the block's outputs. These are an enable, a rate tick for each SCL half period, a start request, the master-mode flag and the own address. The engine reports back through four event pulses, a start acknowledge and a collision pulse. The events are latched into flags that software clears by writing ones. The flags are combined with the mask to drive one interrupt line. When arbitration is lost, master mode is withdrawn and software must set it again.

Top module: `i2cm_regblk`

## Requirements
- R1: After reset every register reads 0x00, and irq, bit_tick, eng_start_req, eng_master and eng_enable are all low.
- R2: The registers sit at byte offsets 0x00 mode, 0x04 own address, 0x08 divider, 0x0C command, 0x10 event and 0x14 mask. Any other offset reads 0x00. Mode keeps only bits 2:0. The own address keeps bits 7:1 and drives own_addr, and its bit 0 reads 0.
- R3: While mode bit 0 (enable) is 0, bit_tick stays low and eng_start_req stays low, even if a start is pending.
- R4: With the block enabled, bit_tick pulses for one cycle every 2^(5-P)×(DIV+3) clock cycles. P is mode bits 2:1 and DIV is the divider register. P=00 gives the divide-by-32 prescale.
- R5: Each one-cycle event input sets its flag. evt_in[0] sets event bit 0 (receive done), evt_in[1] sets bit 1 (transmit done), evt_in[2] sets bit 2 (busy, receive data with no free buffer) and evt_in[3] sets bit 4 (transmit error). Event bits 3, 5, 6 and 7 always read 0.
- R6: Writing the event register clears each bit written as 1 and leaves the bits written as 0. Writing 0xFF clears every flag.
- R7: If an event input and a host clear hit the same flag in the same cycle, the flag stays set.
- R8: irq is high exactly when some event flag and its matching mask bit are both set. A mask of 0x00 holds irq low.
- R9: Writing command bit 7 as 1 sets a pending start. While enabled, eng_start_req is high and command bit 7 reads 1. In the cycle after eng_start_ack is high, both read 0.
- R10: Command bit 0 drives eng_master. A collision pulse clears it, and a collision wins over a host write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-rate reference |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| evt_in | input | 4 | One-cycle event pulses from the bit engine |
| eng_collision | input | 1 | Arbitration lost pulse |
| eng_start_ack | input | 1 | Bit engine has taken the start request |
| eng_enable | output | 1 | Controller enable |
| eng_start_req | output | 1 | Pending start, gated by enable |
| eng_master | output | 1 | Master mode selected |
| own_addr | output | 7 | Own 7-bit address |
| bit_tick | output | 1 | One pulse per SCL half period |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag being set and cleared in the same cycle. To get there, the stimulus drives an event pulse and a write-one-to-clear of the event register on the same falling edge. It then reads back which flags survived. The loss of master mode on a collision is forced the same way, by coinciding a collision pulse with a command write. Rate ticks are measured as the gap between two later ticks, so the partial first period after a reconfiguration is not counted.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DW = 8;
  localparam int NEV = 4;

  localparam int OFS_MODE = 'h00;
  localparam int OFS_OWN  = 'h04;
  localparam int OFS_DIV  = 'h08;
  localparam int OFS_CMD  = 'h0C;
  localparam int OFS_EVT  = 'h10;
  localparam int OFS_MASK = 'h14;

  localparam int MODE_EN_BIT   = 0;
  localparam int MODE_W        = 3;
  localparam int PSEL_W        = 2;
  localparam int CMD_START_BIT = 7;
  localparam int CMD_MSTR_BIT  = 0;

  // Event flag position -> source pulse index, -1 where no flag lives
  function automatic int evt_src(input int pos);
    case (pos)
      0: return 0;
      1: return 1;
      2: return 2;
      4: return 3;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/i2cm_brg.sv
module i2cm_brg #(
  parameter int DIV_W    = 8,
  parameter int PRE_LOG2 = 5,
  parameter int PSEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PSEL_W-1:0] psel,
  input  logic [DIV_W-1:0]  div,
  output logic              tick
);
  localparam int PRE_W  = PRE_LOG2;
  localparam int HALF_W = DIV_W + 2;

  logic [PRE_W-1:0]  pre_cnt, pre_last;
  logic [HALF_W-1:0] half_cnt, half_last;
  logic              pre_hit;

  always_comb begin
    int sh;
    sh = PRE_LOG2 - int'(psel);
    if (sh < 0) sh = 0;
    pre_last  = PRE_W'((1 << sh) - 1);
    half_last = HALF_W'(div) + HALF_W'(2);
    pre_hit   = (pre_cnt >= pre_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      half_cnt <= '0;
      tick     <= 1'b0;
    end else if (!en) begin
      pre_cnt  <= '0;
      half_cnt <= '0;
      tick     <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pre_hit) begin
        pre_cnt <= '0;
        if (half_cnt >= half_last) begin
          half_cnt <= '0;
          tick     <= 1'b1;
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cm_evt.sv
module i2cm_evt
  import i2cm_pkg::*;
#(
  parameter int W = DW,
  parameter int N = NEV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] mask,
  output logic [W-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int SI = evt_src(i);
    if (SI >= 0 && SI < N) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       flags[i] <= 1'b0;
        else if (src[SI])                 flags[i] <= 1'b1;
        else if (clr_we && clr_data[i])   flags[i] <= 1'b0;
      end
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/i2cm_regblk.sv
module i2cm_regblk
  import i2cm_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DIV_W    = 8,
  parameter int PRE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NEV-1:0]    evt_in,
  input  logic              eng_collision,
  input  logic              eng_start_ack,
  output logic              eng_enable,
  output logic              eng_start_req,
  output logic              eng_master,
  output logic [DW-2:0]     own_addr,
  output logic              bit_tick,
  output logic              irq
);
  logic [MODE_W-1:0] mode_q;
  logic [DW-2:0]     own_q;
  logic [DIV_W-1:0]  div_q;
  logic [DW-1:0]     mask_q;
  logic [DW-1:0]     evt_flags;
  logic              start_q, master_q;
  logic              wr_en, hit_mode, hit_own, hit_div, hit_cmd, hit_evt, hit_mask;

  assign wr_en    = bus_sel && bus_wr;
  assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_own  = (bus_addr == ADDR_W'(OFS_OWN));
  assign hit_div  = (bus_addr == ADDR_W'(OFS_DIV));
  assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
  assign hit_evt  = (bus_addr == ADDR_W'(OFS_EVT));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      own_q  <= '0;
      div_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (hit_mode) mode_q <= bus_wdata[MODE_W-1:0];
      if (hit_own)  own_q  <= bus_wdata[DW-1:1];
      if (hit_div)  div_q  <= bus_wdata[DIV_W-1:0];
      if (hit_mask) mask_q <= bus_wdata;
    end
  end

  // Start request: host set wins over acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           start_q <= 1'b0;
    else if (wr_en && hit_cmd && bus_wdata[CMD_START_BIT]) start_q <= 1'b1;
    else if (eng_start_ack)                               start_q <= 1'b0;
  end

  // Master mode: collision wins over a host write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                master_q <= 1'b0;
    else if (eng_collision)    master_q <= 1'b0;
    else if (wr_en && hit_cmd) master_q <= bus_wdata[CMD_MSTR_BIT];
  end

  i2cm_evt #(.W(DW), .N(NEV)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (evt_in),
    .clr_we   (wr_en && hit_evt),
    .clr_data (bus_wdata),
    .mask     (mask_q),
    .flags    (evt_flags),
    .irq      (irq)
  );

  i2cm_brg #(.DIV_W(DIV_W), .PRE_LOG2(PRE_LOG2), .PSEL_W(PSEL_W)) u_brg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (mode_q[MODE_EN_BIT]),
    .psel  (mode_q[PSEL_W:1]),
    .div   (div_q),
    .tick  (bit_tick)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_mode) bus_rdata = DW'(mode_q);
    if (hit_own)  bus_rdata = {own_q, 1'b0};
    if (hit_div)  bus_rdata = DW'(div_q);
    if (hit_cmd) begin
      bus_rdata[CMD_START_BIT] = start_q;
      bus_rdata[CMD_MSTR_BIT]  = master_q;
    end
    if (hit_evt)  bus_rdata = evt_flags;
    if (hit_mask) bus_rdata = mask_q;
  end

  assign eng_enable    = mode_q[MODE_EN_BIT];
  assign eng_start_req = start_q && mode_q[MODE_EN_BIT];
  assign eng_master    = master_q;
  assign own_addr      = own_q;
endmodule

// File: rtl/i2cm_regblk_chk.sv
module i2cm_regblk_chk
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NEV-1:0]    evt_in,
  input logic              eng_collision,
  input logic              eng_start_ack,
  input logic              eng_enable,
  input logic              eng_start_req,
  input logic              eng_master,
  input logic              bit_tick,
  input logic              irq,
  input logic [DW-1:0]     mask_q,
  input logic [DW-1:0]     evt_flags
);
  logic start_write;
  assign start_write = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD)) && bus_wdata[CMD_START_BIT];

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq) else $error("mask zero but irq"); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flags != '0)) else $error("irq with no flag"); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_in[0] |=> evt_flags[0]) else $error("event lost"); // R7

  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start_ack && !start_write) |=> !eng_start_req) else $error("start stuck"); // R9

  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_collision |=> !eng_master) else $error("master kept after collision"); // R10

  AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_enable |=> !bit_tick) else $error("tick while disabled"); // R3

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick) else $error("tick longer than a cycle"); // R4
endmodule

bind i2cm_regblk i2cm_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .evt_in        (evt_in),
  .eng_collision (eng_collision),
  .eng_start_ack (eng_start_ack),
  .eng_enable    (eng_enable),
  .eng_start_req (eng_start_req),
  .eng_master    (eng_master),
  .bit_tick      (bit_tick),
  .irq           (irq),
  .mask_q        (mask_q),
  .evt_flags     (evt_flags)
);

// File: tb/i2cm_regblk_test.sv
module i2cm_regblk_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] evt_in = '0;
  logic       eng_collision = 1'b0, eng_start_ack = 1'b0;
  logic       eng_enable, eng_start_req, eng_master, bit_tick, irq;
  logic [6:0] own_addr;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  bit rd_pend = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  i2cm_regblk uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .eng_collision(eng_collision), .eng_start_ack(eng_start_ack),
    .eng_enable(eng_enable), .eng_start_req(eng_start_req), .eng_master(eng_master),
    .own_addr(own_addr), .bit_tick(bit_tick), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data and compares once the address has settled
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rd_pend && exp_q.size() > 0) begin
        check(32'(bus_rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag); rd_pend = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; rd_pend = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic [3:0] ev, input logic col);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    evt_in = ev; eng_collision = col;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_in = '0; eng_collision = 1'b0;
  endtask

  task automatic pulse_evt(input logic [3:0] ev);
    @(negedge clk); evt_in = ev;
    @(negedge clk); evt_in = '0;
  endtask

  task automatic tick_gap(output int n);
    do @(negedge clk); while (!bit_tick);
    do @(negedge clk); while (!bit_tick);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_tick);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int gap, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check({irq, bit_tick, eng_start_req, eng_master, eng_enable}, 0, "R1 outputs after reset");
    rd(5'h00, 8'h00, "R1 mode reset");
    rd(5'h04, 8'h00, "R1 own reset");
    rd(5'h08, 8'h00, "R1 div reset");
    rd(5'h0C, 8'h00, "R1 cmd reset");
    rd(5'h10, 8'h00, "R1 evt reset");
    rd(5'h14, 8'h00, "R1 mask reset");

    // R2 map and field widths
    wr(5'h04, 8'hFF, 4'h0, 1'b0);
    rd(5'h04, 8'hFE, "R2 own addr bit0 reads 0");
    check(32'(own_addr), 32'h7F, "R2 own_addr port");
    wr(5'h08, 8'hA5, 4'h0, 1'b0);
    rd(5'h08, 8'hA5, "R2 divider readback");
    wr(5'h14, 8'h3C, 4'h0, 1'b0);
    rd(5'h14, 8'h3C, "R2 mask readback");
    wr(5'h00, 8'hF8, 4'h0, 1'b0);
    rd(5'h00, 8'h00, "R2 mode keeps bits 2:0 only");
    rd(5'h18, 8'h00, "R2 unmapped offset");
    rd(5'h02, 8'h00, "R2 unaligned offset");
    wr(5'h14, 8'h00, 4'h0, 1'b0);

    // R5 event positions
    pulse_evt(4'b0001); rd(5'h10, 8'h01, "R5 rxdone bit0");
    pulse_evt(4'b1000); rd(5'h10, 8'h11, "R5 txerr bit4");
    pulse_evt(4'b0110); rd(5'h10, 8'h17, "R5 busy and txdone");
    // R6 write one to clear
    wr(5'h10, 8'h02, 4'h0, 1'b0); rd(5'h10, 8'h15, "R6 clear bit1 only");
    wr(5'h10, 8'hFF, 4'h0, 1'b0); rd(5'h10, 8'h00, "R6 clear all");
    // R7 set wins over clear
    pulse_evt(4'b0011);
    wr(5'h10, 8'h03, 4'b0001, 1'b0);
    rd(5'h10, 8'h01, "R7 set wins, other bit cleared");
    wr(5'h10, 8'hFF, 4'h0, 1'b0);

    // R8 interrupt
    pulse_evt(4'b0010);
    @(negedge clk); #1; check(32'(irq), 0, "R8 mask zero blocks irq");
    wr(5'h14, 8'h01, 4'h0, 1'b0);
    #1; check(32'(irq), 0, "R8 unmatched mask");
    wr(5'h14, 8'h02, 4'h0, 1'b0);
    #1; check(32'(irq), 1, "R8 matched mask");
    wr(5'h10, 8'h02, 4'h0, 1'b0);
    #1; check(32'(irq), 0, "R8 irq drops after clear");
    wr(5'h14, 8'h00, 4'h0, 1'b0);

    // R3 disabled: start held back, no ticks
    wr(5'h0C, 8'h81, 4'h0, 1'b0);
    #1; check(32'(eng_start_req), 0, "R3 start gated while disabled");
    rd(5'h0C, 8'h81, "R9 start pending reads 1");
    wr(5'h08, 8'h00, 4'h0, 1'b0);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (bit_tick) cnt++; end
    check(32'(cnt), 0, "R3 no ticks while disabled");

    // R9 start request and acknowledge
    wr(5'h00, 8'h01, 4'h0, 1'b0);
    #1; check(32'(eng_start_req), 1, "R9 start request when enabled");
    check(32'(eng_master), 1, "R10 master flag");
    repeat (4) @(negedge clk);
    #1; check(32'(eng_start_req), 1, "R9 start held until ack");
    @(negedge clk); eng_start_ack = 1'b1;
    @(negedge clk); eng_start_ack = 1'b0;
    #1; check(32'(eng_start_req), 0, "R9 start cleared after ack");
    rd(5'h0C, 8'h01, "R9 start bit reads 0");

    // R10 collision
    wr(5'h0C, 8'h01, 4'h0, 1'b1);
    #1; check(32'(eng_master), 0, "R10 collision wins over write");
    rd(5'h0C, 8'h00, "R10 master bit cleared");
    wr(5'h0C, 8'h01, 4'h0, 1'b0);
    #1; check(32'(eng_master), 1, "R10 master restored by write");

    // R4 bit rate
    tick_gap(gap); check(32'(gap), 96, "R4 psel 00 div 0");
    wr(5'h08, 8'h02, 4'h0, 1'b0);
    tick_gap(gap); check(32'(gap), 160, "R4 psel 00 div 2");
    wr(5'h08, 8'h01, 4'h0, 1'b0);
    wr(5'h00, 8'h07, 4'h0, 1'b0);
    tick_gap(gap); check(32'(gap), 16, "R4 psel 11 div 1");
    wr(5'h00, 8'h03, 4'h0, 1'b0);
    tick_gap(gap); check(32'(gap), 64, "R4 psel 01 div 1");

    finish_run();
  end
endmodule